// File: doc/BRIEF.md
# Dual-mode SD clock divider

This block derives the SD card clock from a fast core clock. A single 11-bit divisor value stores the division ratio minus two, so the card clock runs at the core frequency divided by (value + 2). The same value is read in two ways:

- **Identification mode.** All eleven bits are used, which gives the slow clocks that card setup needs.
- **Data mode.** Only the three least significant bits are used, which gives fast transfer clocks with total ratios from 2 to 9.

The mode arrives on a plain input. A slow-card configuration bit makes the full-width interpretation apply in both modes. Neither the pads nor the command decoding that selects the mode are part of the block.

The block has two outputs for the card clock. `sd_clk` is a toggled clock level. `sd_clk_en` is a one-core-cycle strobe that marks every rising edge of `sd_clk`, for logic that runs on the core clock. The divisor and the configuration bits are held in registers inside the block and are loaded through write strobes. The two bus-width bits of the configuration pass straight out to the data path. A changed ratio is taken up only at a rising edge of the card clock, so a period that has already started keeps its length.

Top module: `sd_clkdiv`

## Requirements
- R1: While reset is asserted, `sd_clk`, `sd_clk_en`, `wide_ext` and `wide_int` are low, the divisor register reads 507 and all configuration bits are 0. The first rising edge of `sd_clk` comes at the first core edge after reset is released.
- R2: With `data_mode` low, each card clock period lasts divisor + 2 core cycles, using all 11 bits of the divisor.
- R3: With `data_mode` high and configuration bit 3 (slow card) clear, each period lasts divisor[2:0] + 2 core cycles. The upper eight bits are ignored.
- R4: With configuration bit 3 set, each period lasts the full divisor + 2 core cycles in data mode as well.
- R5: For a period of N core cycles, `sd_clk` stays high for ceil(N/2) cycles and then low for floor(N/2) cycles.
- R6: The ratio for a period is fixed by the divisor, the slow bit and `data_mode` as seen at the core edge where `sd_clk` rises. Changes made during the period take effect at the next rising edge.
- R7: `sd_clk_en` is high for exactly one core cycle: the first core cycle of each high phase of `sd_clk`.
- R8: A pulse on `cfg_wr` loads `cfg_wdata` at the same edge. Bit 3 is the slow-card bit, bit 2 drives `wide_ext`, bit 1 drives `wide_int`, and bit 0 is ignored. Both outputs show the new values from the next core cycle on.
- R9: A pulse on `div_wr` loads `div_wdata` at the same edge. The largest value, 0x7FF, gives a period of 2049 core cycles when the full divisor applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_mode | input | 1 | 1 = data transfer mode, 0 = identification mode |
| div_wr | input | 1 | Write strobe for the divisor register |
| div_wdata | input | 11 | New divisor value (ratio minus two) |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 4 | Configuration: bit 3 slow card, bit 2 wide external bus, bit 1 wide internal bus |
| sd_clk | output | 1 | Card clock level |
| sd_clk_en | output | 1 | One-cycle strobe on each card clock rising edge |
| wide_ext | output | 1 | Wide external bus enable, passed through |
| wide_int | output | 1 | Wide internal bus enable, passed through |

## Verification
A register write takes effect at the core edge where its strobe is sampled, so `wide_ext` and `wide_int` are checked one cycle after the write. A new divisor or mode is not checked at that point: it is expected only from the next rising edge of `sd_clk` on. For every period, the bench records the ratio from its own copy of the registers and the mode as they stood when the rise was sampled. It then measures the high phase, the low phase and the whole period in core cycles at the falling core edges, away from the active edge. `sd_clk_en` is compared every cycle against a rise of `sd_clk` observed in that same sample, so a strobe that came one cycle early or one cycle late fails the check.

// File: rtl/sdcd_pkg.sv
`timescale 1ns/1ps
package sdcd_pkg;
  // Configuration register bit positions (software-visible layout).
  localparam int unsigned CFG_W         = 4;
  localparam int unsigned CFG_SLOW_BIT  = 3;
  localparam int unsigned CFG_WEXT_BIT  = 2;
  localparam int unsigned CFG_WINT_BIT  = 1;
  // Fixed offset between stored divisor and actual ratio.
  localparam int unsigned RATIO_OFFSET  = 2;

  typedef struct packed {
    logic slow_card;
    logic wide_ext;
    logic wide_int;
  } sdcd_cfg_t;
endpackage

// File: rtl/sdcd_cfg_regs.sv
`timescale 1ns/1ps
module sdcd_cfg_regs
  import sdcd_pkg::*;
#(
  parameter int unsigned DIV_W   = 11,
  parameter int unsigned DIV_RST = 507
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_wr,
  input  logic [DIV_W-1:0]  div_wdata,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [DIV_W-1:0]  div_q,
  output sdcd_cfg_t         cfg_q
);
  localparam logic [DIV_W-1:0] DIV_RST_V = DIV_W'(DIV_RST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_RST_V;
    end else if (div_wr) begin
      div_q <= div_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_wr) begin
      cfg_q.slow_card <= cfg_wdata[CFG_SLOW_BIT];
      cfg_q.wide_ext  <= cfg_wdata[CFG_WEXT_BIT];
      cfg_q.wide_int  <= cfg_wdata[CFG_WINT_BIT];
    end
  end
endmodule

// File: rtl/sdcd_ratio_sel.sv
`timescale 1ns/1ps
module sdcd_ratio_sel
  import sdcd_pkg::*;
#(
  parameter int unsigned DIV_W  = 11,
  parameter int unsigned FAST_W = 3,
  localparam int unsigned RW    = DIV_W + 1
) (
  input  logic [DIV_W-1:0] div_q,
  input  logic             slow_card,
  input  logic             data_mode,
  output logic [RW-1:0]    ratio
);
  localparam logic [RW-1:0] OFS = RW'(RATIO_OFFSET);

  logic          use_full;
  logic [RW-1:0] full_ratio;
  logic [RW-1:0] fast_ratio;

  assign use_full   = slow_card | ~data_mode;
  assign full_ratio = {1'b0, div_q} + OFS;

  generate
    if (FAST_W >= DIV_W) begin : g_fast_is_full
      assign fast_ratio = full_ratio;
    end else begin : g_fast_narrow
      assign fast_ratio = {{(RW-FAST_W){1'b0}}, div_q[FAST_W-1:0]} + OFS;
    end
  endgenerate

  assign ratio = use_full ? full_ratio : fast_ratio;
endmodule

// File: rtl/sdcd_phase_gen.sv
`timescale 1ns/1ps
module sdcd_phase_gen #(
  parameter int unsigned RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_in,
  output logic          sd_clk,
  output logic          sd_clk_en,
  output logic [RW-1:0] cur_ratio
);
  // After reset the latched ratio is the minimum, so the low phase lasts a
  // single cycle and the first rise loads the real ratio immediately.
  localparam logic [RW-1:0] MIN_RATIO = RW'(2);
  localparam logic [RW-1:0] ONE       = RW'(1);

  logic [RW-1:0] cnt;
  logic [RW-1:0] hi_len;
  logic [RW-1:0] lo_len;
  logic          hi_done;
  logic          lo_done;

  assign hi_len  = (cur_ratio + ONE) >> 1;
  assign lo_len  = cur_ratio >> 1;
  assign hi_done = (cnt == hi_len - ONE);
  assign lo_done = (cnt == lo_len - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_clk    <= 1'b0;
      sd_clk_en <= 1'b0;
      cnt       <= '0;
      cur_ratio <= MIN_RATIO;
    end else begin
      sd_clk_en <= 1'b0;
      if (sd_clk) begin
        if (hi_done) begin
          sd_clk <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + ONE;
        end
      end else begin
        if (lo_done) begin
          sd_clk    <= 1'b1;
          sd_clk_en <= 1'b1;
          cnt       <= '0;
          cur_ratio <= ratio_in;
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end
endmodule

// File: rtl/sd_clkdiv.sv
`timescale 1ns/1ps
module sd_clkdiv
  import sdcd_pkg::*;
#(
  parameter int unsigned DIV_W   = 11,
  parameter int unsigned FAST_W  = 3,
  parameter int unsigned DIV_RST = 507
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_mode,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             cfg_wr,
  input  logic [3:0]       cfg_wdata,
  output logic             sd_clk,
  output logic             sd_clk_en,
  output logic             wide_ext,
  output logic             wide_int
);
  localparam int unsigned RW = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  sdcd_cfg_t        cfg_q;
  logic [RW-1:0]    ratio_sel;
  logic [RW-1:0]    cur_ratio;

  sdcd_cfg_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_wr    (div_wr),
    .div_wdata (div_wdata),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .div_q     (div_q),
    .cfg_q     (cfg_q)
  );

  sdcd_ratio_sel #(.DIV_W(DIV_W), .FAST_W(FAST_W)) u_sel (
    .div_q     (div_q),
    .slow_card (cfg_q.slow_card),
    .data_mode (data_mode),
    .ratio     (ratio_sel)
  );

  sdcd_phase_gen #(.RW(RW)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_in  (ratio_sel),
    .sd_clk    (sd_clk),
    .sd_clk_en (sd_clk_en),
    .cur_ratio (cur_ratio)
  );

  assign wide_ext = cfg_q.wide_ext;
  assign wide_int = cfg_q.wide_int;
endmodule

// File: rtl/sdcd_checker.sv
`timescale 1ns/1ps
module sdcd_checker #(
  parameter int unsigned RW     = 12,
  parameter int unsigned FAST_W = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sd_clk,
  input logic          sd_clk_en,
  input logic [RW-1:0] ratio_sel,
  input logic [RW-1:0] cur_ratio,
  input logic          data_mode,
  input logic          slow_card,
  input logic          cfg_wr,
  input logic [3:0]    cfg_wdata,
  input logic          wide_ext,
  input logic          wide_int
);
  localparam logic [RW-1:0] FAST_LIMIT = RW'((1 << FAST_W) + 2);

  logic [RW-1:0] hi_run;
  logic [RW-1:0] cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= '0;
      cap    <= '0;
    end else if (sd_clk_en) begin
      hi_run <= RW'(1);
      cap    <= cur_ratio;
    end else if (sd_clk) begin
      hi_run <= hi_run + RW'(1);
    end
  end

  assert_en_marks_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_clk_en |-> (sd_clk && !$past(sd_clk)));

  assert_rise_gives_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_clk) |-> sd_clk_en);

  assert_high_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_clk) |-> (hi_run == ((cap + RW'(1)) >> 1)));

  assert_ratio_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_clk_en |-> $stable(cur_ratio));

  assert_fast_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_mode && !slow_card) |-> (ratio_sel < FAST_LIMIT));

  assert_cfg_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (wide_ext == $past(cfg_wdata[2]) && wide_int == $past(cfg_wdata[1])));
endmodule

bind sd_clkdiv sdcd_checker #(.RW(RW), .FAST_W(FAST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sd_clk    (sd_clk),
  .sd_clk_en (sd_clk_en),
  .ratio_sel (ratio_sel),
  .cur_ratio (cur_ratio),
  .data_mode (data_mode),
  .slow_card (cfg_q.slow_card),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .wide_ext  (wide_ext),
  .wide_int  (wide_int)
);

// File: tb/sd_clkdiv_tb.sv
`timescale 1ns/1ps
module sd_clkdiv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        data_mode = 1'b0;
  logic        div_wr = 1'b0;
  logic [10:0] div_wdata = '0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic        sd_clk, sd_clk_en, wide_ext, wide_int;

  always #10 clk = ~clk;

  sd_clkdiv u_dut (
    .clk(clk), .rst_n(rst_n), .data_mode(data_mode), .div_wr(div_wr),
    .div_wdata(div_wdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .sd_clk(sd_clk), .sd_clk_en(sd_clk_en), .wide_ext(wide_ext), .wide_int(wide_int)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Shadow of the register contents, from the requirements.
  logic [10:0] sh_div  = 11'd507;
  logic        sh_slow = 1'b0, sh_wext = 1'b0, sh_wint = 1'b0;
  logic        cur_dm  = 1'b0;

  int    pend_n = 509;
  string pend_tag = "R2";
  int    exp_n = 0;
  string exp_tag = "R2";
  bit    mid_change = 0;
  bit    have_period = 0;
  logic  prev_clk = 1'b0;
  int    hi_cnt = 0, lo_cnt = 0, since_rise = 0;

  function automatic int ratio_of(input logic [10:0] d, input logic slow, input logic dm);
    if (dm && !slow) return int'(d[2:0]) + 2;
    return int'(d) + 2;
  endfunction

  function automatic string tag_of(input logic slow, input logic dm);
    if (!dm) return "R2";
    if (slow) return "R4";
    return "R3";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Sample outputs produced by the edge just passed.
  task automatic observe();
    logic s, e, rise;
    s = sd_clk;
    e = sd_clk_en;
    rise = s && !prev_clk;
    check(e == rise, "R7", int'(e), int'(rise));
    check({wide_ext, wide_int} == {sh_wext, sh_wint}, "R8",
          int'({wide_ext, wide_int}), int'({sh_wext, sh_wint}));
    if (rise) begin
      if (have_period) begin
        check(since_rise == exp_n, mid_change ? "R6" : exp_tag, since_rise, exp_n);
        check(lo_cnt == exp_n / 2, "R5", lo_cnt, exp_n / 2);
      end
      exp_n = pend_n;
      exp_tag = (exp_n == 2049) ? "R9" : pend_tag;
      have_period = 1;
      mid_change = 0;
      hi_cnt = 1; lo_cnt = 0; since_rise = 1;
    end else begin
      since_rise++;
      if (s) hi_cnt++;
      else if (prev_clk) begin
        check(hi_cnt == (exp_n + 1) / 2, "R5", hi_cnt, (exp_n + 1) / 2);
        lo_cnt = 1;
      end else lo_cnt++;
    end
    prev_clk = s;
  endtask

  // Drive inputs for the next edge and record the ratio that edge would use.
  task automatic drive(input logic dm, input logic dwr, input logic [10:0] dd,
                       input logic cwr, input logic [3:0] cd);
    int n;
    data_mode = dm; div_wr = dwr; div_wdata = dd; cfg_wr = cwr; cfg_wdata = cd;
    cur_dm = dm;
    n = ratio_of(sh_div, sh_slow, dm);
    if (n != pend_n) mid_change = 1;
    pend_n = n;
    pend_tag = tag_of(sh_slow, dm);
    if (dwr) sh_div = dd;
    if (cwr) begin
      sh_slow = cd[3]; sh_wext = cd[2]; sh_wint = cd[1];
    end
  endtask

  task automatic step(input logic dm, input logic dwr, input logic [10:0] dd,
                      input logic cwr, input logic [3:0] cd);
    @(negedge clk);
    observe();
    drive(dm, dwr, dd, cwr, cd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(cur_dm, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    void'($urandom(32'h5D1C_0A77));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check({sd_clk, sd_clk_en, wide_ext, wide_int} == 4'b0, "R1",
            int'({sd_clk, sd_clk_en, wide_ext, wide_int}), 0);
    end
    rst_n = 1'b1;
    drive(1'b0, 1'b0, '0, 1'b0, '0);
    step(1'b0, 1'b0, '0, 1'b0, '0);
    check(prev_clk == 1'b1, "R1", int'(prev_clk), 1);
    // Reset divisor 507 in identification mode: period 509
    idle(1100);
    // Largest divisor, full width
    step(1'b0, 1'b1, 11'h7FF, 1'b0, '0);
    idle(4200);
    // Data mode, fast path uses low bits only (0x7FF -> 9)
    step(1'b1, 1'b0, '0, 1'b0, '0);
    idle(200);
    step(1'b1, 1'b1, 11'd0, 1'b0, '0);   idle(60);
    step(1'b1, 1'b1, 11'd3, 1'b0, '0);   idle(60);
    step(1'b1, 1'b1, 11'h7F8, 1'b0, '0); idle(60);
    step(1'b1, 1'b1, 11'd7, 1'b0, '0);   idle(60);
    // Slow-card bit forces full divisor in data mode
    step(1'b1, 1'b1, 11'd12, 1'b1, 4'b1110); idle(80);
    step(1'b1, 1'b0, '0, 1'b1, 4'b0110);     idle(80);
    step(1'b1, 1'b0, '0, 1'b1, 4'b1001);     idle(80);
    // Changes in the middle of long periods
    step(1'b0, 1'b1, 11'd40, 1'b0, '0); idle(50);
    for (int i = 0; i < 30; i++) begin
      step(i[0], 1'b1, 11'(i), 1'b0, '0);
      idle(5);
    end
    // Constrained random
    for (int i = 0; i < 20000; i++) begin
      int r;
      logic dm, dwr, cwr;
      logic [10:0] dd;
      r = int'($urandom_range(0, 999));
      dm = cur_dm;
      if (r < 25) dm = ~cur_dm;
      dwr = (r >= 25 && r < 45);
      dd = (r < 28 || r >= 43) ? 11'($urandom_range(0, 2047)) : 11'($urandom_range(0, 20));
      if (dd > 11'd200 && r != 44) dd = 11'($urandom_range(0, 20));
      cwr = (r >= 45 && r < 60);
      step(dm, dwr, dd, cwr, 4'($urandom_range(0, 15)));
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule